// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. Software reaches both registers through a small configuration port. Writes take effect at the next clock edge, and reads are combinational. Slot-side events come in as single-cycle pulses: hot-add, a device found at power-up, and an attention-button press. The block latches each event into the status register. It decides whether a hot-plug notification is pending. It then reports that decision in one of two ways: as a level interrupt, or as a one-cycle message-request pulse.

Every write to the control register is one command, and that command completes in the cycle it is applied. Two control bit combinations have side effects. A write that turns the slot off with its power indicator off, while a device is present, produces a detach request toward the secondary bus. A self-clearing control bit flips the modelled electromechanical interlock. While the interlock is engaged, hot-add requests are refused with a busy flag.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Reset with `slot_filled`=0 leaves control = 0x07C0 (attention indicator bits 7:6 = 11 off, power indicator bits 9:8 = 11 off, power controller bit 10 = 1 off) and status = 0x0000. Reset with `slot_filled`=1 leaves control = 0x01C0 (power indicator 01 on, power controller 0 on) and status = 0x0040 (presence state bit 6). The interlock status bit 7 and the event bits 0, 3 and 4 are clear after reset.
- R2: A control write (`cfg_addr`=0) loads bits 0, 3, 4, 5, 7:6, 9:8 and 10 from `cfg_wdata`. Bit 11 (interlock control) and every other bit always read back as 0.
- R3: Every control write sets command-completed status bit 4 in the same update.
- R4: A control write with bit 11 set inverts interlock status bit 7.
- R5: A status write (`cfg_addr`=1) clears each of bits 0 (attention pressed), 3 (presence changed) and 4 (command completed) that is written as 1. Writes have no effect on bits 6 and 7.
- R6: A notification is pending when control bit 5 is set and, for at least one of bits 0, 3 and 4, both the status bit and the enable at the same position in control are set. With `msg_mode`=0, `irq_level` equals the pending condition one cycle after the register update.
- R7: With `msg_mode`=1, `msg_pulse` is high for one cycle when the pending condition changes because of an event or a control write. There is no pulse when an event repeats a status bit that is already set. There is no pulse when a status write alone clears the pending condition. `irq_level` stays low in this mode.
- R8: A `hot_add` pulse while bit 7 is 0 sets bits 6, 3 and 0. While bit 7 is 1, `hot_add_err` is high in the same cycle and status does not change.
- R9: A `coldplug` pulse sets bit 6 without raising any event. An `attn_btn` pulse sets bit 0.
- R10: If bit 6 is set and a control write has bit 10 = 1 and bits 9:8 = 11, then bit 6 clears, bits 3 and 4 set, and `detach_req` pulses for one cycle. Any other power and indicator combination requests no detach.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_filled | input | 1 | Slot occupancy used for the reset values |
| msg_mode | input | 1 | 1 selects message pulses, 0 selects the level interrupt |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects control, 1 selects status |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| hot_add | input | 1 | Runtime hot-add request pulse |
| hot_add_err | output | 1 | Busy: hot-add refused because the interlock is engaged |
| coldplug | input | 1 | Device found at power-up pulse |
| attn_btn | input | 1 | Attention button pulse |
| irq_level | output | 1 | Level interrupt (legacy mode) |
| msg_pulse | output | 1 | Message request pulse (message mode) |
| detach_req | output | 1 | Detach request toward the secondary bus |

## Verification
The assertions check, on every cycle, the local effects of single operations:
- command completion after each control write;
- the interlock flip;
- the status bits set by hot-add and by the attention button;
- the busy flag while the interlock is engaged;
- the status effects that go with a detach request;
- a level interrupt only while the global enable is set.

Other behaviour can only be shown by the bench's scenarios, because it depends on history:
- whether the pending condition changed, and what caused the change;
- that repeated events and status-only clears send no message;
- that bits 6 and 7 ignore writes;
- the exact reset values for an empty and for a filled slot.

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slot_filled,
  input  logic         msg_mode,
  input  logic         cfg_wr,
  input  logic         cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  input  logic         hot_add,
  output logic         hot_add_err,
  input  logic         coldplug,
  input  logic         attn_btn,
  output logic         irq_level,
  output logic         msg_pulse,
  output logic         detach_req
);
  localparam int B_ABP = 0, B_PDC = 3, B_CC = 4, B_HPIE = 5;
  localparam int B_PCC = 10, B_EIC = 11, B_PDS = 6, B_EIS = 7;
  localparam logic [W-1:0] CTL_WMASK = W'(16'h07F9);
  localparam logic [W-1:0] EV_MASK   = W'(16'h0019);
  localparam logic [W-1:0] CTL_EMPTY = W'(16'h07C0);
  localparam logic [W-1:0] CTL_FULL  = W'(16'h01C0);

  logic [W-1:0] ctl_q, sts_q, ctl_n, sts_n;
  logic pend_q, pend_n, pulse_q, det_q, det_n, cause;
  logic wr_ctl, wr_sts, add_ok;

  assign wr_ctl = cfg_wr && !cfg_addr;
  assign wr_sts = cfg_wr && cfg_addr;
  assign add_ok = hot_add && !sts_q[B_EIS];
  assign hot_add_err = hot_add && sts_q[B_EIS];

  always_comb begin
    ctl_n = ctl_q;
    sts_n = sts_q;
    det_n = 1'b0;
    cause = 1'b0;
    if (wr_ctl) begin
      ctl_n = cfg_wdata & CTL_WMASK;
      if (cfg_wdata[B_EIC]) sts_n[B_EIS] = ~sts_q[B_EIS];
      if (sts_q[B_PDS] && cfg_wdata[B_PCC] && cfg_wdata[9:8] == 2'b11) begin
        sts_n[B_PDS] = 1'b0;
        sts_n[B_PDC] = 1'b1;
        det_n = 1'b1;
      end
      sts_n[B_CC] = 1'b1;
      cause = 1'b1;
    end
    if (wr_sts) sts_n = sts_n & ~(cfg_wdata & EV_MASK);
    if (coldplug) sts_n[B_PDS] = 1'b1;
    if (attn_btn) begin
      sts_n[B_ABP] = 1'b1;
      cause = 1'b1;
    end
    if (add_ok) begin
      sts_n[B_PDS] = 1'b1;
      sts_n[B_PDC] = 1'b1;
      sts_n[B_ABP] = 1'b1;
      cause = 1'b1;
    end
  end

  assign pend_n = ctl_n[B_HPIE] && |(sts_n & ctl_n & EV_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= slot_filled ? CTL_FULL : CTL_EMPTY;
      sts_q   <= slot_filled ? W'(16'h0040) : '0;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
      det_q   <= 1'b0;
    end else begin
      ctl_q   <= ctl_n;
      sts_q   <= sts_n;
      pend_q  <= pend_n;
      pulse_q <= msg_mode && cause && (pend_n != pend_q);
      det_q   <= det_n;
    end
  end

  assign cfg_rdata  = cfg_addr ? sts_q : ctl_q;
  assign irq_level  = pend_q && !msg_mode;
  assign msg_pulse  = pulse_q;
  assign detach_req = det_q;
endmodule

module hp_slot_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        cfg_addr,
  input logic [15:0] cfg_wdata,
  input logic        hot_add,
  input logic        hot_add_err,
  input logic        attn_btn,
  input logic        irq_level,
  input logic        detach_req,
  input logic [15:0] ctl_q,
  input logic [15:0] sts_q
);
  p_cmd_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_addr) |=> sts_q[4]);
  p_lock_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_addr && cfg_wdata[11]) |=> (sts_q[7] != $past(sts_q[7])));
  p_add_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_add && !sts_q[7]) |=> (sts_q[6] && sts_q[3] && sts_q[0]));
  p_add_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_add && sts_q[7]) |-> hot_add_err);
  p_attn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    attn_btn |=> sts_q[0]);
  p_detach_r10: assert property (@(posedge clk) disable iff (!rst_n)
    detach_req |-> (sts_q[3] && sts_q[4] && $past(sts_q[6])));
  p_irq_hpie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level |-> ctl_q[5]);
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .hot_add(hot_add), .hot_add_err(hot_add_err),
  .attn_btn(attn_btn), .irq_level(irq_level), .detach_req(detach_req),
  .ctl_q(ctl_q), .sts_q(sts_q)
);

// File: tb/hp_slot_ctrl_tb_top.sv
`timescale 1ns/1ps
module hp_slot_ctrl_tb_top;
  logic clk = 0, rst_n = 0, slot_filled = 0, msg_mode = 0;
  logic cfg_wr = 0, cfg_addr = 0, hot_add = 0, coldplug = 0, attn_btn = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic hot_add_err, irq_level, msg_pulse, detach_req;
  int n_run = 0, n_fail = 0;
  logic [15:0] rc, rs;
  logic s_irq, s_pulse, s_det, s_err;

  always #10 clk = ~clk;

  hp_slot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .slot_filled(slot_filled), .msg_mode(msg_mode),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hot_add(hot_add), .hot_add_err(hot_add_err), .coldplug(coldplug),
    .attn_btn(attn_btn), .irq_level(irq_level), .msg_pulse(msg_pulse),
    .detach_req(detach_req)
  );

  localparam logic [2:0] OP_WC = 0, OP_WS = 1, OP_ADD = 2, OP_ATT = 3, OP_COLD = 4;
  // {op, data, exp_ctl, exp_sts, exp_irq, exp_detach}
  localparam logic [52:0] VEC [17] = '{
    {OP_ATT,  16'h0000, 16'h07C0, 16'h0001, 1'b0, 1'b0},  // R9
    {OP_WC,   16'h0021, 16'h0021, 16'h0011, 1'b1, 1'b0},  // R2 R3 R6
    {OP_WS,   16'h0001, 16'h0021, 16'h0010, 1'b0, 1'b0},  // R5
    {OP_ATT,  16'h0000, 16'h0021, 16'h0011, 1'b1, 1'b0},  // R6
    {OP_ATT,  16'h0000, 16'h0021, 16'h0011, 1'b1, 1'b0},  // R6 repeat
    {OP_WS,   16'h0019, 16'h0021, 16'h0000, 1'b0, 1'b0},  // R5
    {OP_ADD,  16'h0000, 16'h0021, 16'h0049, 1'b1, 1'b0},  // R8
    {OP_WC,   16'h0831, 16'h0031, 16'h00D9, 1'b1, 1'b0},  // R4 R2
    {OP_ADD,  16'h0000, 16'h0031, 16'h00D9, 1'b1, 1'b0},  // R8 refused
    {OP_WS,   16'h0019, 16'h0031, 16'h00C0, 1'b0, 1'b0},  // R5
    {OP_WC,   16'h0800, 16'h0000, 16'h0050, 1'b0, 1'b0},  // R4
    {OP_WC,   16'h0730, 16'h0730, 16'h0018, 1'b1, 1'b1},  // R10
    {OP_COLD, 16'h0000, 16'h0730, 16'h0058, 1'b1, 1'b0},  // R9
    {OP_WC,   16'h0630, 16'h0630, 16'h0058, 1'b1, 1'b0},  // R10 blink, no detach
    {OP_WS,   16'h0018, 16'h0630, 16'h0040, 1'b0, 1'b0},  // R5
    {OP_WC,   16'h0130, 16'h0130, 16'h0050, 1'b1, 1'b0},  // R3 R10
    {OP_WS,   16'h00C0, 16'h0130, 16'h0050, 1'b1, 1'b0}   // R5 bits 6,7
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sample();
    cfg_addr = 0; #1 rc = cfg_rdata;
    cfg_addr = 1; #1 rs = cfg_rdata;
    s_irq = irq_level; s_pulse = msg_pulse; s_det = detach_req;
  endtask

  task automatic do_op(logic [2:0] op, logic [15:0] d);
    @(negedge clk);
    cfg_wr = (op == OP_WC || op == OP_WS);
    cfg_addr = (op == OP_WS);
    cfg_wdata = d;
    hot_add = (op == OP_ADD);
    attn_btn = (op == OP_ATT);
    coldplug = (op == OP_COLD);
    #1 s_err = hot_add_err;
    @(negedge clk);
    cfg_wr = 0; hot_add = 0; attn_btn = 0; coldplug = 0;
    sample();
  endtask

  task automatic do_reset(logic filled, logic mm);
    @(negedge clk);
    rst_n = 0; slot_filled = filled; msg_mode = mm;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sample();
  endtask

  initial begin
    do_reset(0, 0);
    check("R1 ctl empty", rc, 16'h07C0);
    check("R1 sts empty", rs, 16'h0000);
    check("R1 irq", {15'b0, s_irq}, 16'h0);

    foreach (VEC[i]) begin
      do_op(VEC[i][52:50], VEC[i][49:34]);
      check($sformatf("R2/R3 ctl vec%0d", i), rc, VEC[i][33:18]);
      check($sformatf("R5/R8 sts vec%0d", i), rs, VEC[i][17:2]);
      check($sformatf("R6 irq vec%0d", i), {15'b0, s_irq}, {15'b0, VEC[i][1]});
      check($sformatf("R10 detach vec%0d", i), {15'b0, s_det}, {15'b0, VEC[i][0]});
      check($sformatf("R7 no pulse legacy vec%0d", i), {15'b0, s_pulse}, 16'h0);
    end

    // R8 busy flag
    do_op(OP_WC, 16'h0800);
    do_op(OP_ADD, 0);
    check("R8 busy flag", {15'b0, s_err}, 16'h1);
    check("R8 sts unchanged", rs[7:6], 2'b11);
    do_op(OP_WC, 16'h0800);
    do_op(OP_ADD, 0);
    check("R8 no busy", {15'b0, s_err}, 16'h0);

    // R1 filled reset, interlock released
    do_op(OP_WC, 16'h0800);
    do_reset(1, 1);
    check("R1 ctl filled", rc, 16'h01C0);
    check("R1 sts filled", rs, 16'h0040);

    // R7 message mode
    do_op(OP_WC, 16'h0021);
    check("R7 no pulse without event", {15'b0, s_pulse}, 16'h0);
    do_op(OP_ATT, 0);
    check("R7 pulse on rise", {15'b0, s_pulse}, 16'h1);
    check("R7 irq low in msg mode", {15'b0, s_irq}, 16'h0);
    do_op(OP_ATT, 0);
    check("R7 repeat event no pulse", {15'b0, s_pulse}, 16'h0);
    do_op(OP_WS, 16'h0001);
    check("R7 status clear no pulse", {15'b0, s_pulse}, 16'h0);
    do_op(OP_ATT, 0);
    check("R7 pulse again", {15'b0, s_pulse}, 16'h1);
    do_op(OP_WC, 16'h0000);
    check("R7 pulse on ctl fall", {15'b0, s_pulse}, 16'h1);
    check("R2 ctl cleared", rc, 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule